// File: doc/BRIEF.md
# Serial EEPROM Slave Emulator

This block behaves as a small serial-bus EEPROM of 1,024 bytes held in an on-chip register array. It connects to an SPI master in Mode 0 and answers four one-byte commands: write enable (0x06), write (0x02), read (0x03) and status read (0x05). Read and write each carry a 16-bit address, most significant bit first. Only the low 10 bits of that address select a byte.

All SPI inputs are brought into the system clock domain and edge-detected there, so the serial clock must run several times slower than the system clock. A write is accepted only if an earlier chip-select frame set the write-enable latch. A write stays inside its 64-byte block, wrapping around within it. When the frame that carried it ends, the write starts a timed internal cycle whose length in system clocks comes from an input port. While that cycle runs, only status reads are answered.

Top module: `spi_eeprom_emu`

## Requirements
- R1: A frame carrying opcode 0x06 sets the write-enable latch, which status bit 1 then reports as 1.
- R2: Opcode 0x05 returns the status byte {6'b0, latch, busy}: bit 0 is busy and bit 1 is the write-enable latch. The byte is sent again for each further 8 clocks in the same frame.
- R3: Opcode 0x02, a 16-bit address and data bytes store the data when the latch is set. Only address bits [9:0] are used; bits [15:10] are ignored.
- R4: Each written byte advances the low 6 address bits only. A write that passes the last byte of a 64-byte block continues at the first byte of the same block.
- R5: A write frame sent while the latch is clear leaves the array unchanged, and the latch stays clear.
- R6: While wp_n is low when the write opcode arrives, the array is unchanged. The latch is cleared when that frame ends.
- R7: After a write frame with at least one data byte ends, busy is 1 for max(wc_ticks,1) system clocks. The latch clears when busy falls.
- R8: While busy, every opcode except 0x05 is ignored: reads drive no data and write enable has no effect.
- R9: Opcode 0x03 plus address streams bytes from that address for as long as the clock runs. The address wraps from 0x3FF to 0x000.
- R10: mosi is sampled on sclk rising edges and miso changes after falling edges. miso_oe is high only in the data phase of a read or status command.
- R11: While hold_n is low, sclk edges are ignored and miso_oe is low. The frame resumes where it stopped when hold_n returns high.
- R12: After reset the latch and busy are clear and miso_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from master |
| wp_n | input | 1 | Write protect, active low |
| hold_n | input | 1 | Pause, active low |
| wc_ticks | input | WCW (24) | Internal write-cycle length in system clocks |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for miso |

## Verification
The bench uses the default sizes: 1,024 bytes in 64-byte blocks. This places the block-wrap boundary (0x07F to 0x040) and the array-end wrap (0x3FF to 0x000) within a few short frames. The serial clock has a half period of six system clocks, which leaves room for the input synchronizers. wc_ticks is set to 30 for the table of single-byte writes. It is raised to 1,000 for the busy test, so that a status read, a refused read and a refused write enable all fit inside one write cycle.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  typedef enum logic [2:0] {
    S_OPC,
    S_ADH,
    S_ADL,
    S_WDAT,
    S_RDAT,
    S_STAT,
    S_SKIP
  } eep_st_t;
endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
  parameter int          W       = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end
endmodule

// File: rtl/eep_wcycle_timer.sv
module eep_wcycle_timer #(
  parameter int WCW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [WCW-1:0] ticks,
  output logic           busy,
  output logic           done
);
  logic [WCW-1:0] cnt_q, cnt_n;
  logic           busy_q, busy_n;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done   = 1'b0;
    if (start) begin
      cnt_n  = (ticks == '0) ? WCW'(1) : ticks;
      busy_n = 1'b1;
    end else if (busy_q) begin
      if (cnt_q <= WCW'(1)) begin
        busy_n = 1'b0;
        done   = 1'b1;
      end else begin
        cnt_n = cnt_q - WCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/spi_eeprom_emu.sv
module spi_eeprom_emu
  import eep_pkg::*;
#(
  parameter int MEM_BYTES   = 1024,
  parameter int BLOCK_BYTES = 64,
  parameter int WCW         = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           mosi,
  input  logic           wp_n,
  input  logic           hold_n,
  input  logic [WCW-1:0] wc_ticks,
  output logic           miso,
  output logic           miso_oe
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int BW = $clog2(BLOCK_BYTES);

  // reset: asserted asynchronously, released on a clock edge
  logic rs1_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q  <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rs1_q  <= 1'b1;
      rst_ni <= rs1_q;
    end
  end

  // pin synchronizers: {cs, sclk, mosi, wp, hold}
  logic [4:0] pins_s;
  eep_pin_sync #(.W(5), .RST_VAL(5'b10011)) u_sync (
    .clk(clk), .rst_n(rst_ni),
    .d({cs_n, sclk, mosi, wp_n, hold_n}), .q(pins_s)
  );
  logic cs_s, sclk_s, mosi_s, wp_s, hold_s;
  assign {cs_s, sclk_s, mosi_s, wp_s, hold_s} = pins_s;

  logic sclk_d, cs_d;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  logic sclk_rise, sclk_fall, cs_rise, live;
  assign live      = !cs_s && hold_s;
  assign sclk_rise = live && sclk_s && !sclk_d;
  assign sclk_fall = live && !sclk_s && sclk_d;
  assign cs_rise   = cs_s && !cs_d;

  // write-cycle timer
  logic wc_start, wc_busy, wc_done;
  eep_wcycle_timer #(.WCW(WCW)) u_timer (
    .clk(clk), .rst_n(rst_ni), .start(wc_start), .ticks(wc_ticks),
    .busy(wc_busy), .done(wc_done)
  );

  // array
  logic          mem_we;
  logic [7:0]    mem_rd;
  logic [AW-1:0] addr_q, addr_n;
  logic [7:0]    rx_byte;
  eep_mem #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(addr_q), .wdata(rx_byte),
    .raddr(addr_q), .rdata(mem_rd)
  );

  // command engine state
  eep_st_t    st_q, st_n;
  logic [2:0] bit_q, bit_n;
  logic [7:0] sh_q, sh_n;
  logic [7:0] out_q, out_n;
  logic       wok_q, wok_n;
  logic       wcmd_q, wcmd_n;
  logic       wrote_q, wrote_n;
  logic       wel_q, wel_n;
  logic       wel_set;
  logic [7:0] status;

  assign rx_byte = {sh_q[6:0], mosi_s};
  assign status  = {6'b0, wel_q, wc_busy};

  always_comb begin
    st_n    = st_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    out_n   = out_q;
    addr_n  = addr_q;
    wok_n   = wok_q;
    wcmd_n  = wcmd_q;
    wrote_n = wrote_q;
    mem_we  = 1'b0;
    wel_set = 1'b0;
    if (cs_s) begin
      st_n    = S_OPC;
      bit_n   = '0;
      wcmd_n  = 1'b0;
      wrote_n = 1'b0;
      wok_n   = 1'b0;
    end else if (sclk_rise) begin
      sh_n  = rx_byte;
      bit_n = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        unique case (st_q)
          S_OPC: begin
            if (wc_busy && rx_byte != OP_RDSR) begin
              st_n = S_SKIP;
            end else begin
              unique case (rx_byte)
                OP_WREN: begin
                  wel_set = 1'b1;
                  st_n    = S_SKIP;
                end
                OP_WRITE: begin
                  st_n   = S_ADH;
                  wcmd_n = 1'b1;
                  wok_n  = wel_q && wp_s;
                end
                OP_READ:  st_n = S_ADH;
                OP_RDSR:  st_n = S_STAT;
                default:  st_n = S_SKIP;
              endcase
            end
          end
          S_ADH: begin
            addr_n[AW-1:8] = rx_byte[AW-9:0];
            st_n           = S_ADL;
          end
          S_ADL: begin
            addr_n[7:0] = rx_byte;
            st_n        = wcmd_q ? S_WDAT : S_RDAT;
          end
          S_WDAT: begin
            mem_we  = wok_q;
            addr_n  = {addr_q[AW-1:BW], addr_q[BW-1:0] + 1'b1};
            wrote_n = wrote_q || wok_q;
          end
          default: ;
        endcase
      end
    end else if (sclk_fall) begin
      if (bit_q == 3'd0 && st_q == S_RDAT) begin
        out_n  = mem_rd;
        addr_n = addr_q + 1'b1;
      end else if (bit_q == 3'd0 && st_q == S_STAT) begin
        out_n = status;
      end else begin
        out_n = {out_q[6:0], 1'b0};
      end
    end
  end

  // latch and write-cycle launch at the end of a frame
  always_comb begin
    wc_start = cs_rise && wcmd_q && wrote_q;
    wel_n    = wel_q;
    if (wel_set) wel_n = 1'b1;
    if (wc_done) wel_n = 1'b0;
    if (cs_rise && wcmd_q && !wrote_q) wel_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_OPC;
      bit_q   <= '0;
      sh_q    <= '0;
      out_q   <= '0;
      addr_q  <= '0;
      wok_q   <= 1'b0;
      wcmd_q  <= 1'b0;
      wrote_q <= 1'b0;
      wel_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      out_q   <= out_n;
      addr_q  <= addr_n;
      wok_q   <= wok_n;
      wcmd_q  <= wcmd_n;
      wrote_q <= wrote_n;
      wel_q   <= wel_n;
    end
  end

  assign miso    = out_q[7];
  assign miso_oe = live && (st_q == S_RDAT || st_q == S_STAT);
endmodule

// File: rtl/eep_emu_checker.sv
module eep_emu_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic wel,
  input logic cs_rise,
  input logic mem_we
);
  // R7: a write cycle starts only at the end of a frame
  a_r7_busy_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));
  // R7: the latch stays set for the whole write cycle
  a_r7_wel_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wel);
  // R7: the latch is clear once the cycle ends
  a_r7_wel_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R8: write enable is refused while busy
  a_r8_no_wren_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(!busy));
  // R8: the array is not written during a write cycle
  a_r8_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !busy);
endmodule

bind spi_eeprom_emu eep_emu_checker u_chk (
  .clk(clk), .rst_n(rst_ni), .busy(wc_busy), .wel(wel_q),
  .cs_rise(cs_rise), .mem_we(mem_we)
);

// File: tb/spi_eeprom_emu_bench.sv
module spi_eeprom_emu_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
  logic [23:0] wc_ticks = 24'd30;
  logic miso, miso_oe;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom_emu u_spi_eeprom_emu (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .wp_n(wp_n), .hold_n(hold_n), .wc_ticks(wc_ticks),
    .miso(miso), .miso_oe(miso_oe)
  );

  // {address as sent, data}
  localparam logic [23:0] VEC [6] = '{
    {16'hFC80, 8'h55}, {16'h03FF, 8'hC3}, {16'h0400, 8'h3C},
    {16'h0123, 8'hA5}, {16'h02C0, 8'h5A}, {16'h8001, 8'h81}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0; ticks(HALF);
  endtask

  task automatic cs_hi();
    ticks(HALF); cs_n = 1'b1; ticks(HALF + 4);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe);
    oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      ticks(HALF);
      rx[i] = miso;
      oe = oe | miso_oe;
      sclk = 1'b1;
      ticks(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r; bit o;
    cs_lo(); xfer(op, r, o); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    bit o;
    cs_lo(); xfer(8'h05, s, o); xfer(8'h00, s, o); cs_hi();
  endtask

  task automatic wr_bytes(input logic [15:0] a, input logic [7:0] d [], input int n);
    logic [7:0] r; bit o;
    cs_lo(); xfer(8'h02, r, o); xfer(a[15:8], r, o); xfer(a[7:0], r, o);
    for (int k = 0; k < n; k++) xfer(d[k], r, o);
    cs_hi();
  endtask

  task automatic rd_start(input logic [15:0] a);
    logic [7:0] r; bit o;
    cs_lo(); xfer(8'h03, r, o); xfer(a[15:8], r, o); xfer(a[7:0], r, o);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, r, d [];
    bit o;
    ticks(5); rst_n = 1'b1; ticks(5);

    // R12: reset state
    chk(miso_oe == 1'b0, "R12 oe after reset", miso_oe, 0);
    rdsr(s);
    chk(s == 8'h00, "R12 status after reset", s, 8'h00);

    // R10: no drive during opcode; R1/R2: latch and repeated status
    cs_lo(); xfer(8'h06, r, o); cs_hi();
    chk(o == 1'b0, "R10 oe during opcode", o, 0);
    cs_lo(); xfer(8'h05, r, o);
    chk(o == 1'b0, "R10 oe during status opcode", o, 0);
    xfer(8'h00, s, o);
    chk(s == 8'h02, "R1 latch set", s, 8'h02);
    chk(o == 1'b1, "R10 oe in status data", o, 1);
    xfer(8'h00, s, o);
    chk(s == 8'h02, "R2 status repeats", s, 8'h02);
    cs_hi();
    cmd1(8'h04); // unused opcode, latch left alone is not required; rewrite below

    // R3: table of single-byte writes, address bits above 9 ignored
    for (int v = 0; v < 6; v++) begin
      cmd1(8'h06);
      d = new[1]; d[0] = VEC[v][7:0];
      wr_bytes(VEC[v][23:8], d, 1);
      ticks(60);
    end
    for (int v = 0; v < 6; v++) begin
      rd_start({6'b0, VEC[v][17:8]});
      xfer(8'h00, r, o); cs_hi();
      chk(r == VEC[v][7:0], "R3 write readback", r, VEC[v][7:0]);
      chk(o == 1'b1, "R10 oe in read data", o, 1);
    end
    rdsr(s);
    chk(s == 8'h00, "R7 latch cleared after cycle", s, 8'h00);

    // R9: continuous read wraps 0x3FF -> 0x000 -> 0x001
    rd_start(16'h03FF);
    xfer(8'h00, r, o); chk(r == 8'hC3, "R9 read 3FF", r, 8'hC3);
    xfer(8'h00, r, o); chk(r == 8'h3C, "R9 wrap to 000", r, 8'h3C);
    xfer(8'h00, r, o); chk(r == 8'h81, "R9 then 001", r, 8'h81);
    cs_hi();

    // R4: block wrap, write 0x07E..: A0 A1 then A2 A3 at 0x040
    cmd1(8'h06);
    d = new[4]; d = '{8'hA0, 8'hA1, 8'hA2, 8'hA3};
    wr_bytes(16'h007E, d, 4);
    ticks(60);
    rd_start(16'h007E);
    xfer(8'h00, r, o); chk(r == 8'hA0, "R4 byte 07E", r, 8'hA0);
    xfer(8'h00, r, o); chk(r == 8'hA1, "R4 byte 07F", r, 8'hA1);
    xfer(8'h00, r, o); chk(r == 8'h55, "R4 080 untouched", r, 8'h55);
    cs_hi();
    rd_start(16'h0040);
    xfer(8'h00, r, o); chk(r == 8'hA2, "R4 wrapped 040", r, 8'hA2);
    xfer(8'h00, r, o); chk(r == 8'hA3, "R4 wrapped 041", r, 8'hA3);
    cs_hi();

    // R5: write with latch clear
    d = new[1]; d[0] = 8'hEE;
    wr_bytes(16'h0080, d, 1);
    ticks(60);
    rdsr(s); chk(s == 8'h00, "R5 no latch no busy", s, 8'h00);
    rd_start(16'h0080); xfer(8'h00, r, o); cs_hi();
    chk(r == 8'h55, "R5 array unchanged", r, 8'h55);

    // R6: write protect
    cmd1(8'h06);
    wp_n = 1'b0;
    d[0] = 8'h99;
    wr_bytes(16'h0080, d, 1);
    wp_n = 1'b1;
    ticks(60);
    rdsr(s); chk(s == 8'h00, "R6 latch cleared", s, 8'h00);
    rd_start(16'h0080); xfer(8'h00, r, o); cs_hi();
    chk(r == 8'h55, "R6 array unchanged", r, 8'h55);

    // R11: hold pauses a read in progress
    rd_start(16'h0080);
    ticks(HALF);
    hold_n = 1'b0; ticks(4);
    chk(miso_oe == 1'b0, "R11 oe released in hold", miso_oe, 0);
    for (int k = 0; k < 8; k++) begin
      mosi = k[0]; ticks(3); sclk = 1'b1; ticks(3); sclk = 1'b0;
    end
    ticks(2);
    chk(miso_oe == 1'b0, "R11 oe still released", miso_oe, 0);
    hold_n = 1'b1; ticks(4);
    xfer(8'h00, r, o); cs_hi();
    chk(r == 8'h55, "R11 read resumes unshifted", r, 8'h55);

    // R7/R8: long write cycle
    wc_ticks = 24'd1000;
    cmd1(8'h06);
    d[0] = 8'h77;
    wr_bytes(16'h0123, d, 1);
    rdsr(s); chk(s == 8'h03, "R7 busy and latch", s, 8'h03);
    rd_start(16'h0123); xfer(8'h00, r, o); cs_hi();
    chk(o == 1'b0, "R8 read refused while busy", o, 0);
    cmd1(8'h06);
    ticks(500);
    rdsr(s); chk(s == 8'h00, "R8 wren ignored, R7 done", s, 8'h00);
    rd_start(16'h0123); xfer(8'h00, r, o); cs_hi();
    chk(r == 8'h77, "R7 data stored", r, 8'h77);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule